// File: doc/BRIEF.md
# Boot Strap Latch and Low-Window Alias Remapper

This block decides which physical memory answers in the low code window that starts at address zero. After reset is released, it counts rising clock edges and captures the two boot strap inputs on a fixed edge. It also captures the second-bank boot option on that edge. It decodes the captured values into an alias target. Until that capture has happened, the fetch enable output stays low and incoming requests are stalled, so the CPU cannot read its initial stack pointer at 0x0 or its reset vector at 0x4 too early. When the device leaves standby, the same counting and capture run again.

Each accepted request gives one registered response one cycle later. An address inside the 64 MB low window is translated to the base of the current alias target plus its offset. The response reports an error when the offset lies beyond the size of that memory. Addresses outside the window pass through unchanged, so every memory also stays reachable at its own home address. Software may write a 2-bit remap code to place flash, system memory, SRAM1 or the external bank in the window. A later reset or standby exit discards that code in favour of the strap decode.

Top module: `boot_alias_remap`

## Requirements
- R1: After reset is released, fetch_en stays low through the first three rising edges and goes high right after the fourth. The strap and option values present at that fourth edge are the ones captured. Later changes on those inputs have no effect.
- R2: A standby_exit pulse seen at a rising edge clears fetch_en after that edge. The straps are then captured again on the fourth rising edge that follows it, and fetch_en rises after that edge.
- R3: Alias target codes are 0 = main flash, 1 = system memory, 2 = SRAM1, 3 = external bank. The strap decode is as follows. strap_lo = 0 gives flash, whatever strap_hi is. strap_lo = 1 with strap_hi = 0 gives system memory. strap_lo = 1 with strap_hi = 1 gives SRAM1.
- R4: When alt_bank_boot is 1 at the capture edge and the straps decode to flash, the captured target is system memory.
- R5: While fetch_en is low, a request is not accepted and produces no response.
- R6: A request accepted at an edge gives rsp_valid = 1 for exactly the following cycle. For an address below 0x0400_0000, rsp_hit = 1, rsp_sel is the current target, and rsp_addr = target base + address. The bases are flash 0x0800_0000, system memory 0x1FFF_0000, SRAM1 0x2000_0000 and external 0x6000_0000. Address 0x0 therefore maps to the base and 0x4 to base + 4.
- R7: For an address at or above 0x0400_0000, rsp_hit = 0, rsp_err = 0 and rsp_addr equals the request address.
- R8: For an in-window address, rsp_err = 1 exactly when the address is at or above the size of the current target. The sizes are flash 0x20_0000, system memory 0x7800, SRAM1 0x2_8000 and external 0x400_0000.
- R9: A remap write while fetch_en is high and no standby_exit is present sets the target used for requests accepted at later edges. A request accepted at the same edge as the write still uses the previous target. A write while fetch_en is low is ignored.
- R10: Every reset and every standby re-capture replace the target with the strap decode, discarding any earlier software remap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strap_lo | input | 1 | Boot strap that selects flash when low |
| strap_hi | input | 1 | Boot strap that selects SRAM1 over system memory |
| alt_bank_boot | input | 1 | Second-bank boot option bit |
| standby_exit | input | 1 | One-cycle pulse when the device leaves standby |
| remap_we | input | 1 | Software remap write strobe |
| remap_sel | input | 2 | Software remap target code |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| fetch_en | output | 1 | Capture complete; requests accepted while high |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Address fell inside the low window |
| rsp_sel | output | 2 | Alias target used for the response |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_err | output | 1 | Offset beyond the size of the target |

## Verification
Two pairs of events can fall on the same edge. The first pair is a remap write and a request. The bench drives both in one cycle and expects the response to that request to carry the previous target. It expects the next request to carry the written one. The second pair is a standby exit and a request. The request must still be answered with the old target. The bench then holds the request through the re-capture window and expects no response. After the new capture, it expects a response that uses the strap decode and not the software code.

// File: rtl/boot_alias_remap_pkg.sv
package boot_alias_remap_pkg;

   localparam int NUM_TGT = 4;

   typedef enum logic [1:0] {
      TGT_FLASH  = 2'd0,
      TGT_SYSMEM = 2'd1,
      TGT_SRAM   = 2'd2,
      TGT_EXT    = 2'd3
   } alias_tgt_t;

   // strap_lo low picks flash (or system memory when the second-bank option
   // is set); otherwise strap_hi chooses between system memory and SRAM.
   function automatic alias_tgt_t decode_straps(input logic lo,
                                                input logic hi,
                                                input logic alt);
      alias_tgt_t t;
      if (!lo)
         t = alt ? TGT_SYSMEM : TGT_FLASH;
      else if (!hi)
         t = TGT_SYSMEM;
      else
         t = TGT_SRAM;
      return t;
   endfunction

endpackage

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
   import boot_alias_remap_pkg::*;
#(
   parameter int SAMPLE_EDGE = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       pin_lo,
   input  logic       pin_hi,
   input  logic       alt_bank,
   output logic       done,
   output logic       capture,
   output alias_tgt_t decoded
);

   localparam int CW = (SAMPLE_EDGE > 2) ? $clog2(SAMPLE_EDGE) : 1;
   localparam logic [CW-1:0] LAST = CW'(SAMPLE_EDGE - 1);

   logic [CW-1:0] edge_cnt;

   initial begin
      assert (SAMPLE_EDGE >= 1)
         else $error("SAMPLE_EDGE must be at least 1");
   end

   // The capture edge is the SAMPLE_EDGE-th edge since reset release or since
   // the edge that saw a restart pulse.
   assign capture = !done && !restart && (edge_cnt == LAST);
   assign decoded = decode_straps(pin_lo, pin_hi, alt_bank);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         done     <= 1'b0;
      end else if (restart) begin
         edge_cnt <= '0;
         done     <= 1'b0;
      end else if (!done) begin
         if (edge_cnt == LAST) begin
            edge_cnt <= '0;
            done     <= 1'b1;
         end else begin
            edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/alias_mode_reg.sv
module alias_mode_reg
   import boot_alias_remap_pkg::*;
#(
   parameter bit SW_REMAP_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  alias_tgt_t decoded,
   input  logic       sw_allow,
   input  logic       sw_we,
   input  logic [1:0] sw_sel,
   output alias_tgt_t mode
);

   alias_tgt_t mode_q;
   assign mode = mode_q;

   generate
      if (SW_REMAP_EN) begin : g_sw
         // A capture always wins over a software write in the same cycle.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= TGT_FLASH;
            else if (capture)
               mode_q <= decoded;
            else if (sw_we && sw_allow)
               mode_q <= alias_tgt_t'(sw_sel);
         end
      end else begin : g_fixed
         logic unused_sw;
         assign unused_sw = ^{sw_allow, sw_we, sw_sel};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mode_q <= TGT_FLASH;
            else if (capture)
               mode_q <= decoded;
         end
      end
   endgenerate

endmodule

// File: rtl/alias_translator.sv
module alias_translator
   import boot_alias_remap_pkg::*;
#(
   parameter int              AW         = 32,
   parameter int              WIN_BITS   = 26,
   parameter logic [AW-1:0]   FLASH_BASE = 'h0800_0000,
   parameter logic [AW-1:0]   SYS_BASE   = 'h1FFF_0000,
   parameter logic [AW-1:0]   SRAM_BASE  = 'h2000_0000,
   parameter logic [AW-1:0]   EXT_BASE   = 'h6000_0000,
   parameter logic [AW-1:0]   FLASH_SIZE = 'h0020_0000,
   parameter logic [AW-1:0]   SYS_SIZE   = 'h0000_7800,
   parameter logic [AW-1:0]   SRAM_SIZE  = 'h0002_8000,
   parameter logic [AW-1:0]   EXT_SIZE   = 'h0400_0000
)(
   input  alias_tgt_t  mode,
   input  logic [AW-1:0] addr,
   output logic        hit,
   output logic [AW-1:0] xaddr,
   output logic        err
);

   localparam logic [AW-1:0] BASES [NUM_TGT] = '{FLASH_BASE, SYS_BASE, SRAM_BASE, EXT_BASE};
   localparam logic [AW-1:0] SIZES [NUM_TGT] = '{FLASH_SIZE, SYS_SIZE, SRAM_SIZE, EXT_SIZE};

   logic [AW-1:0]                 offset;
   logic [NUM_TGT-1:0][AW-1:0]    cand_addr;
   logic [NUM_TGT-1:0]            cand_over;

   initial begin
      assert (WIN_BITS >= 1 && WIN_BITS <= AW)
         else $error("WIN_BITS out of range");
   end

   generate
      if (WIN_BITS < AW) begin : g_part
         assign hit    = (addr[AW-1:WIN_BITS] == '0);
         assign offset = {{(AW-WIN_BITS){1'b0}}, addr[WIN_BITS-1:0]};
      end else begin : g_full
         assign hit    = 1'b1;
         assign offset = addr;
      end
   endgenerate

   // One adder and one limit compare per target; the mode picks one of them.
   generate
      for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
         assign cand_addr[g] = BASES[g] + offset;
         assign cand_over[g] = (offset >= SIZES[g]);
      end
   endgenerate

   always_comb begin
      if (hit) begin
         xaddr = cand_addr[mode];
         err   = cand_over[mode];
      end else begin
         xaddr = addr;
         err   = 1'b0;
      end
   end

endmodule

// File: rtl/boot_alias_remap.sv
module boot_alias_remap
   import boot_alias_remap_pkg::*;
#(
   parameter int            AW          = 32,
   parameter int            WIN_BITS    = 26,
   parameter int            SAMPLE_EDGE = 4,
   parameter bit            SW_REMAP_EN = 1'b1,
   parameter logic [AW-1:0] FLASH_BASE  = 'h0800_0000,
   parameter logic [AW-1:0] SYS_BASE    = 'h1FFF_0000,
   parameter logic [AW-1:0] SRAM_BASE   = 'h2000_0000,
   parameter logic [AW-1:0] EXT_BASE    = 'h6000_0000,
   parameter logic [AW-1:0] FLASH_SIZE  = 'h0020_0000,
   parameter logic [AW-1:0] SYS_SIZE    = 'h0000_7800,
   parameter logic [AW-1:0] SRAM_SIZE   = 'h0002_8000,
   parameter logic [AW-1:0] EXT_SIZE    = 'h0400_0000
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strap_lo,
   input  logic          strap_hi,
   input  logic          alt_bank_boot,
   input  logic          standby_exit,
   input  logic          remap_we,
   input  logic [1:0]    remap_sel,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          fetch_en,
   output logic          rsp_valid,
   output logic          rsp_hit,
   output logic [1:0]    rsp_sel,
   output logic [AW-1:0] rsp_addr,
   output logic          rsp_err
);

   logic          done;
   logic          capture;
   alias_tgt_t    decoded;
   alias_tgt_t    mode;
   logic          accept;
   logic          x_hit;
   logic          x_err;
   logic [AW-1:0] x_addr;

   boot_strap_sampler #(
      .SAMPLE_EDGE (SAMPLE_EDGE)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (standby_exit),
      .pin_lo   (strap_lo),
      .pin_hi   (strap_hi),
      .alt_bank (alt_bank_boot),
      .done     (done),
      .capture  (capture),
      .decoded  (decoded)
   );

   alias_mode_reg #(
      .SW_REMAP_EN (SW_REMAP_EN)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .decoded  (decoded),
      .sw_allow (done && !standby_exit),
      .sw_we    (remap_we),
      .sw_sel   (remap_sel),
      .mode     (mode)
   );

   alias_translator #(
      .AW         (AW),
      .WIN_BITS   (WIN_BITS),
      .FLASH_BASE (FLASH_BASE),
      .SYS_BASE   (SYS_BASE),
      .SRAM_BASE  (SRAM_BASE),
      .EXT_BASE   (EXT_BASE),
      .FLASH_SIZE (FLASH_SIZE),
      .SYS_SIZE   (SYS_SIZE),
      .SRAM_SIZE  (SRAM_SIZE),
      .EXT_SIZE   (EXT_SIZE)
   ) u_xlat (
      .mode  (mode),
      .addr  (req_addr),
      .hit   (x_hit),
      .xaddr (x_addr),
      .err   (x_err)
   );

   assign fetch_en = done;
   assign accept   = req_valid && done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_sel   <= 2'd0;
         rsp_addr  <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_hit  <= x_hit;
            rsp_sel  <= mode;
            rsp_addr <= x_addr;
            rsp_err  <= x_err;
         end
      end
   end

endmodule

// File: rtl/boot_alias_remap_chk.sv
module boot_alias_remap_chk #(
   parameter int AW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          standby_exit,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          fetch_en,
   input logic          rsp_valid,
   input logic          rsp_hit,
   input logic [AW-1:0] rsp_addr,
   input logic          rsp_err
);

   assert_capture_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_en) |-> $past(!fetch_en, 3));

   assert_standby_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_exit && fetch_en) |=> !fetch_en);

   assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !fetch_en) |=> !rsp_valid);

   assert_rsp_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && fetch_en));

   assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr) && !rsp_err));

   assert_err_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> rsp_hit);

endmodule

bind boot_alias_remap boot_alias_remap_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .standby_exit (standby_exit),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .fetch_en     (fetch_en),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_addr     (rsp_addr),
   .rsp_err      (rsp_err)
);

// File: tb/boot_alias_remap_test.sv
`timescale 1ns/1ps
module boot_alias_remap_test;

   localparam logic [31:0] WIN = 32'h0400_0000;
   localparam logic [31:0] BASE [4] = '{32'h0800_0000, 32'h1FFF_0000, 32'h2000_0000, 32'h6000_0000};
   localparam logic [31:0] SIZE [4] = '{32'h0020_0000, 32'h0000_7800, 32'h0002_8000, 32'h0400_0000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_lo = 1'b0, strap_hi = 1'b0, alt_bank_boot = 1'b0;
   logic        standby_exit = 1'b0;
   logic        remap_we = 1'b0;
   logic [1:0]  remap_sel = 2'd0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        fetch_en, rsp_valid, rsp_hit, rsp_err;
   logic [1:0]  rsp_sel;
   logic [31:0] rsp_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   boot_alias_remap uut (
      .clk(clk), .rst_n(rst_n), .strap_lo(strap_lo), .strap_hi(strap_hi),
      .alt_bank_boot(alt_bank_boot), .standby_exit(standby_exit),
      .remap_we(remap_we), .remap_sel(remap_sel), .req_valid(req_valid),
      .req_addr(req_addr), .fetch_en(fetch_en), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_sel(rsp_sel), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int decode(input bit lo, input bit hi, input bit alt);
      if (!lo) return alt ? 1 : 0;
      return hi ? 2 : 1;
   endfunction

   // Requests one address and judges the response against the arithmetic model.
   task automatic probe(input string tag, input int m, input logic [31:0] a);
      bit hit;
      req_valid = 1'b1;
      req_addr  = a;
      tick();
      req_valid = 1'b0;
      hit = (a < WIN);
      check({tag, " R6 valid"}, {31'd0, rsp_valid}, 32'd1);
      check({tag, " R7 hit"}, {31'd0, rsp_hit}, {31'd0, hit});
      if (hit) begin
         check({tag, " R6 sel"}, {30'd0, rsp_sel}, m);
         check({tag, " R6 addr"}, rsp_addr, BASE[m] + a);
         check({tag, " R8 err"}, {31'd0, rsp_err}, {31'd0, a >= SIZE[m]});
      end else begin
         check({tag, " R7 addr"}, rsp_addr, a);
         check({tag, " R7 err"}, {31'd0, rsp_err}, 32'd0);
      end
      tick();
      check({tag, " R6 one-shot"}, {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic sw_write(input int m);
      remap_we  = 1'b1;
      remap_sel = 2'(m);
      tick();
      remap_we  = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 R3 R4: sweep all strap/option values; wrong values until just
      // before the fourth edge, the real values at it, garbage after.
      for (int v = 0; v < 8; v++) begin
         bit lo, hi, alt;
         int m;
         lo = v[0]; hi = v[1]; alt = v[2];
         m = decode(lo, hi, alt);
         rst_n = 1'b0;
         strap_lo = ~lo; strap_hi = ~hi; alt_bank_boot = ~alt;
         tick(); tick();
         check("R1 reset fetch_en", {31'd0, fetch_en}, 32'd0);
         check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
         rst_n = 1'b1;
         for (int e = 1; e <= 3; e++) begin
            tick();
            check("R1 fetch_en before capture", {31'd0, fetch_en}, 32'd0);
         end
         strap_lo = lo; strap_hi = hi; alt_bank_boot = alt;
         tick();
         check("R1 fetch_en after fourth edge", {31'd0, fetch_en}, 32'd1);
         strap_lo = ~lo; strap_hi = ~hi; alt_bank_boot = ~alt;
         probe("R3 R4 decode", m, 32'h0000_0000);
         probe("R6 vector", m, 32'h0000_0004);
      end

      // R9 R6 R7 R8: every software target across window corners.
      for (int m = 0; m < 4; m++) begin
         logic [31:0] pts [8];
         sw_write(m);
         pts = '{32'h0, 32'h4, SIZE[m] - 32'h4, SIZE[m], WIN - 32'h4,
                 32'h0800_0000, 32'h2000_0010, 32'hFFFF_FFFC};
         foreach (pts[i]) probe("R9 sweep", m, pts[i]);
      end

      // R9: remap write and request on the same edge.
      sw_write(3);
      remap_we = 1'b1; remap_sel = 2'd0;
      req_valid = 1'b1; req_addr = 32'h100;
      tick();
      remap_we = 1'b0; req_valid = 1'b0;
      check("R9 same-edge uses old target", rsp_addr, BASE[3] + 32'h100);
      check("R9 same-edge old sel", {30'd0, rsp_sel}, 32'd3);
      tick();
      probe("R9 next request new target", 0, 32'h100);

      // R2 R5 R10: standby exit on the same edge as a request.
      sw_write(3);
      strap_lo = 1'b1; strap_hi = 1'b1; alt_bank_boot = 1'b0;
      standby_exit = 1'b1; req_valid = 1'b1; req_addr = 32'h40;
      tick();
      standby_exit = 1'b0;
      check("R2 request at exit answered", {31'd0, rsp_valid}, 32'd1);
      check("R2 answered with old target", rsp_addr, BASE[3] + 32'h40);
      check("R2 fetch_en dropped", {31'd0, fetch_en}, 32'd0);
      remap_we = 1'b1; remap_sel = 2'd1;   // R9: ignored while fetch_en low
      for (int e = 1; e <= 3; e++) begin
         tick();
         check("R5 stalled no response", {31'd0, rsp_valid}, 32'd0);
         check("R2 fetch_en low in window", {31'd0, fetch_en}, 32'd0);
      end
      remap_we = 1'b0;
      tick();
      check("R2 fetch_en after recapture", {31'd0, fetch_en}, 32'd1);
      check("R5 no response at recapture", {31'd0, rsp_valid}, 32'd0);
      tick();
      req_valid = 1'b0;
      check("R10 recapture response", {31'd0, rsp_valid}, 32'd1);
      check("R10 strap decode wins", rsp_addr, BASE[2] + 32'h40);

      // R10: reset discards a software code.
      sw_write(3);
      rst_n = 1'b0;
      strap_lo = 1'b0; strap_hi = 1'b0; alt_bank_boot = 1'b0;
      tick();
      rst_n = 1'b1;
      repeat (4) tick();
      probe("R10 reset restores decode", 0, 32'h8);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule